// File: doc/BRIEF.md
# Six-Channel Low-Side Gate Control with Short-Circuit Retry

This block is the digital control core for six low-side power switch channels. Each channel takes its on/off command either from a latched serial command word or from a dedicated parallel input pin; one select pin picks the source for all channels at once. Two PWM group inputs gate the outer channel pairs: `pwmLow` gates channels 0 and 1, and `pwmHigh` gates channels 4 and 5. Channels 2 and 3 follow their command directly. The result is registered into a gate-enable output per channel. Two global supply flags, power over-voltage and logic-supply-low, force every gate off.

Each channel watches a drain-high comparator bit. It qualifies a disagreement between the drain and the drive state through a blanking delay that restarts at every gate transition. A channel that is on while its drain stays high is flagged as shorted to supply. The channel then moves into a latched retry mode. In that mode the gate is enabled for one tick of a prescaled timer out of every 64 ticks, and the drain is re-examined at the end of each on-window. A channel that is commanded off while its drain stays low is flagged as an open load or a short to ground. The fault outputs are levels: each clears as soon as its condition is gone.

Top module: `hsd_gate_ctl`

## Requirements
- R1: With `selParallel`=1 the command of channel i is `parIn[i]`; with `selParallel`=0 it is `serialCmd[i]`. `gateEn[i]` reflects the gated command one clock edge after the inputs change.
- R2: For channels 0 and 1 the command is ANDed with `pwmLow`; for channels 4 and 5 it is ANDed with `pwmHigh`.
- R3: Channels 2 and 3 ignore both PWM group inputs.
- R4: A channel whose gate is on while `drainHigh` stays 1 raises `fault[i]` on the (blankLimit+1)-th clock edge after the gate turned on. The fault is not raised earlier. The channel then enters retry mode.
- R5: A channel that is commanded off, with its gate off and settled past the blanking delay, raises `fault[i]` one edge after `drainHigh[i]` falls to 0. It clears `fault[i]` one edge after `drainHigh[i]` returns to 1.
- R6: `overVolt`=1 forces every `gateEn` to 0 one edge later. The gates resume one edge after the flag drops.
- R7: `logicLow`=1 forces every `gateEn` to 0 one edge later.
- R8: In retry mode with the command held on and the drain still high, the gate is on for exactly PRESC cycles out of every 64*PRESC cycles.
- R9: In retry mode, if the drain reads low at the end of an on-window, the channel leaves retry mode. `fault[i]` clears and the gate stays on continuously.
- R10: A channel in retry mode that is commanded off leaves retry mode. `fault[i]` and `gateEn[i]` read 0 one edge later, provided the drain is high.
- R11: After reset all gate enables and fault bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| blankLimit | input | 8 | Blanking delay in cycles after a gate transition |
| serialCmd | input | 6 | Latched serial on/off command, one bit per channel |
| parIn | input | 6 | Parallel on/off command pins |
| selParallel | input | 1 | 1 selects parallel pins, 0 selects serial command |
| pwmLow | input | 1 | PWM gate for channels 0 and 1 |
| pwmHigh | input | 1 | PWM gate for channels 4 and 5 |
| drainHigh | input | 6 | Drain comparator result, 1 = drain voltage high |
| overVolt | input | 1 | Power-supply over-voltage flag |
| logicLow | input | 1 | Logic-supply-low flag |
| gateEn | output | 6 | Registered gate enable per channel |
| fault | output | 6 | Level fault flag per channel |

## Verification
The assertions assume that the drain comparator bits, the command bits and the supply flags are synchronous to `clk` and change only between edges. They also assume that `blankLimit` is held constant while a channel is being qualified. The stimulus changes every input on the falling clock edge. During random runs it models healthy loads by setting each drain bit to the inverse of the gate that the block currently drives. Faults come only from the directed cases, which force a drain level that contradicts the drive. `blankLimit` changes only while no channel is mid-qualification.

// File: rtl/hsd_gate_pkg.sv
package hsd_gate_pkg;
  // Strobes from the retry timebase to the channel datapath
  typedef struct packed {
    logic tick;      // one-cycle pulse every PRESC clocks
    logic windowOn;  // high during the retry on-window tick
  } retry_strb_t;
endpackage

// File: rtl/hsd_retry_timer.sv
module hsd_retry_timer
  import hsd_gate_pkg::*;
#(
  parameter int PRESC  = 8,
  parameter int PERIOD = 64
) (
  input  logic        clk,
  input  logic        rstN,
  output retry_strb_t strb
);
  localparam int PW = (PRESC > 1) ? $clog2(PRESC) : 1;
  localparam int FW = $clog2(PERIOD);

  logic [PW-1:0] prescCnt;
  logic [FW-1:0] phase;
  logic          tickNow;

  assign tickNow = (prescCnt == PW'(PRESC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescCnt <= '0;
      phase    <= '0;
    end else begin
      prescCnt <= tickNow ? '0 : prescCnt + 1'b1;
      if (tickNow) phase <= (phase == FW'(PERIOD - 1)) ? '0 : phase + 1'b1;
    end
  end

  assign strb.tick     = tickNow;
  assign strb.windowOn = (phase == '0);

  generate
    if (PRESC > 1) begin : g_spacing
      // R8
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
        strb.tick |=> !strb.tick);
    end
  endgenerate
endmodule

// File: rtl/hsd_channel.sv
module hsd_channel
  import hsd_gate_pkg::*;
#(
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  retry_strb_t        strb,
  input  logic [BLANK_W-1:0] blankLimit,
  input  logic               cmd,
  input  logic               pwmOk,
  input  logic               kill,
  input  logic               drainHigh,
  output logic               gateEn,
  output logic               fault
);
  localparam logic [BLANK_W-1:0] CNT_MAX = {BLANK_W{1'b1}};

  logic [BLANK_W-1:0] blankCnt;
  logic               shortLatched;
  logic               openFlag;
  logic               gateNext;
  logic               settled;
  logic               shortDet;
  logic               openDet;
  logic               retryPass;

  assign gateNext  = !kill && cmd && pwmOk && (!shortLatched || strb.windowOn);
  assign settled   = (blankCnt >= blankLimit);
  assign shortDet  = gateEn && drainHigh && settled;
  assign openDet   = !cmd && !gateEn && !drainHigh && settled;
  assign retryPass = strb.windowOn && strb.tick && gateEn && !drainHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gateEn       <= 1'b0;
      blankCnt     <= '0;
      shortLatched <= 1'b0;
      openFlag     <= 1'b0;
    end else begin
      gateEn <= gateNext;
      if (gateNext != gateEn)    blankCnt <= '0;
      else if (blankCnt != CNT_MAX) blankCnt <= blankCnt + 1'b1;
      if (!cmd)                          shortLatched <= 1'b0;
      else if (shortLatched && retryPass) shortLatched <= 1'b0;
      else if (shortDet)                 shortLatched <= 1'b1;
      openFlag <= openDet;
    end
  end

  assign fault = shortLatched | openFlag;

  // R6
  kill_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    kill |=> !gateEn);

  // R8
  retry_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (shortLatched && !strb.windowOn) |=> !gateEn);

  // R4
  latch_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(shortLatched) |-> $past(gateEn && drainHigh));

  // R5
  open_gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fault && !shortLatched) |-> !gateEn);
endmodule

// File: rtl/hsd_channel_bank.sv
module hsd_channel_bank
  import hsd_gate_pkg::*;
#(
  parameter int NCH     = 6,
  parameter int BLANK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  retry_strb_t        strb,
  input  logic [BLANK_W-1:0] blankLimit,
  input  logic [NCH-1:0]     serialCmd,
  input  logic [NCH-1:0]     parIn,
  input  logic               selParallel,
  input  logic               pwmLow,
  input  logic               pwmHigh,
  input  logic [NCH-1:0]     drainHigh,
  input  logic               overVolt,
  input  logic               logicLow,
  output logic [NCH-1:0]     gateEn,
  output logic [NCH-1:0]     fault
);
  logic [NCH-1:0] cmdVec;
  logic [NCH-1:0] pwmVec;
  logic           kill;

  assign cmdVec = selParallel ? parIn : serialCmd;
  assign kill   = overVolt | logicLow;

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      if (i < 2) begin : g_grpLow
        assign pwmVec[i] = pwmLow;
      end else if (i >= NCH - 2) begin : g_grpHigh
        assign pwmVec[i] = pwmHigh;
      end else begin : g_direct
        assign pwmVec[i] = 1'b1;
      end

      hsd_channel #(.BLANK_W(BLANK_W)) u_ch (
        .clk        (clk),
        .rstN       (rstN),
        .strb       (strb),
        .blankLimit (blankLimit),
        .cmd        (cmdVec[i]),
        .pwmOk      (pwmVec[i]),
        .kill       (kill),
        .drainHigh  (drainHigh[i]),
        .gateEn     (gateEn[i]),
        .fault      (fault[i])
      );
    end
  endgenerate

  // R7
  supply_kill_chk: assert property (@(posedge clk) disable iff (!rstN)
    logicLow |=> (gateEn == '0));
endmodule

// File: rtl/hsd_gate_ctl.sv
module hsd_gate_ctl
  import hsd_gate_pkg::*;
#(
  parameter int NCH     = 6,
  parameter int BLANK_W = 8,
  parameter int PRESC   = 8,
  parameter int PERIOD  = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [BLANK_W-1:0] blankLimit,
  input  logic [NCH-1:0]     serialCmd,
  input  logic [NCH-1:0]     parIn,
  input  logic               selParallel,
  input  logic               pwmLow,
  input  logic               pwmHigh,
  input  logic [NCH-1:0]     drainHigh,
  input  logic               overVolt,
  input  logic               logicLow,
  output logic [NCH-1:0]     gateEn,
  output logic [NCH-1:0]     fault
);
  retry_strb_t strb;

  hsd_retry_timer #(.PRESC(PRESC), .PERIOD(PERIOD)) u_timer (
    .clk  (clk),
    .rstN (rstN),
    .strb (strb)
  );

  hsd_channel_bank #(.NCH(NCH), .BLANK_W(BLANK_W)) u_bank (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .blankLimit  (blankLimit),
    .serialCmd   (serialCmd),
    .parIn       (parIn),
    .selParallel (selParallel),
    .pwmLow      (pwmLow),
    .pwmHigh     (pwmHigh),
    .drainHigh   (drainHigh),
    .overVolt    (overVolt),
    .logicLow    (logicLow),
    .gateEn      (gateEn),
    .fault       (fault)
  );
endmodule

// File: tb/hsd_gate_ctl_tb.sv
`timescale 1ns/1ps
module hsd_gate_ctl_tb;
  localparam int PRESC  = 8;
  localparam int PERIOD = 64;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] blankLimit = 8'd4;
  logic [5:0] serialCmd = '0;
  logic [5:0] parIn = '0;
  logic       selParallel = 1'b0;
  logic       pwmLow = 1'b1;
  logic       pwmHigh = 1'b1;
  logic [5:0] drainHigh = 6'h3f;
  logic       overVolt = 1'b0;
  logic       logicLow = 1'b0;
  logic [5:0] gateEn;
  logic [5:0] fault;

  int  checks = 0;
  int  fails = 0;
  bit  trackDrain = 1'b1;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  hsd_gate_ctl u_dut (
    .clk(clk), .rstN(rstN), .blankLimit(blankLimit), .serialCmd(serialCmd),
    .parIn(parIn), .selParallel(selParallel), .pwmLow(pwmLow), .pwmHigh(pwmHigh),
    .drainHigh(drainHigh), .overVolt(overVolt), .logicLow(logicLow),
    .gateEn(gateEn), .fault(fault)
  );

  function automatic logic [5:0] expGate(logic [5:0] sc, logic [5:0] pi, logic sel,
                                         logic pl, logic ph, logic ov, logic ll);
    logic [5:0] c;
    logic [5:0] g;
    c = sel ? pi : sc;
    for (int i = 0; i < 6; i++) begin
      if (i < 2)       g[i] = c[i] & pl;
      else if (i >= 4) g[i] = c[i] & ph;
      else             g[i] = c[i];
    end
    if (ov || ll) g = '0;
    return g;
  endfunction

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
    if (trackDrain) drainHigh = ~gateEn;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    int hi;
    bit found;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 gate reset", gateEn, 6'h00);
    check("R11 fault reset", fault, 6'h00);
    rstN = 1'b1;
    cycle();

    // R1 serial source
    serialCmd = 6'b101101; parIn = 6'b010010; selParallel = 1'b0;
    cycle();
    check("R1 serial source", gateEn, 6'b101101);
    // R1 parallel source
    selParallel = 1'b1;
    cycle();
    check("R1 parallel source", gateEn, 6'b010010);
    selParallel = 1'b0; serialCmd = 6'h3f;

    // R2 / R3 PWM groups
    pwmLow = 1'b0; pwmHigh = 1'b1;
    cycle();
    check("R2 R3 low group gated", gateEn, 6'b111100);
    pwmLow = 1'b1; pwmHigh = 1'b0;
    cycle();
    check("R2 R3 high group gated", gateEn, 6'b001111);
    pwmLow = 1'b0; pwmHigh = 1'b0;
    cycle();
    check("R3 middle channels ignore pwm", gateEn, 6'b001100);
    pwmLow = 1'b1; pwmHigh = 1'b1;
    cycle();
    check("R2 all on", gateEn, 6'h3f);

    // R6 over-voltage
    overVolt = 1'b1;
    cycle();
    check("R6 overvolt kills", gateEn, 6'h00);
    overVolt = 1'b0;
    cycle();
    check("R6 overvolt release", gateEn, 6'h3f);
    // R7 logic supply low
    logicLow = 1'b1;
    cycle();
    check("R7 logic low kills", gateEn, 6'h00);
    logicLow = 1'b0;
    cycle();
    check("R7 logic low release", gateEn, 6'h3f);
    check("R6 R7 no spurious fault", fault, 6'h00);

    // idle all channels
    serialCmd = '0;
    repeat (10) cycle();

    // R5 open load on channel 3
    trackDrain = 1'b0;
    drainHigh = 6'b110111;
    cycle();
    check("R5 open flagged", fault, 6'b001000);
    drainHigh = 6'h3f;
    cycle();
    check("R5 open cleared", fault, 6'h00);

    // R4 short on channel 2 with blanking 4
    serialCmd = 6'b000100;
    for (int s = 1; s <= 6; s++) begin
      cycle();
      if (s == 1) check("R4 gate on", gateEn, 6'b000100);
      if (s == 5) check("R4 no fault within blanking", fault, 6'h00);
      if (s == 6) check("R4 short flagged", fault, 6'b000100);
    end

    // R8 retry duty
    repeat (PRESC * PERIOD + 4) cycle();
    hi = 0;
    for (int k = 0; k < PRESC * PERIOD; k++) begin
      cycle();
      if (gateEn[2]) hi++;
    end
    check("R8 retry on-cycles", 6'(hi), 6'(PRESC));
    check("R8 fault held", fault, 6'b000100);

    // R9 recovery at window end
    drainHigh = 6'b111011;
    found = 1'b0;
    for (int k = 0; k < PRESC * PERIOD + 8; k++) begin
      cycle();
      if (!found && fault == 6'h00) begin
        found = 1'b1;
        check("R9 gate on at recovery", gateEn, 6'b000100);
      end
    end
    check("R9 fault cleared", {5'b0, found}, 6'd1);
    check("R9 gate stays on", gateEn, 6'b000100);

    // R10 exit by command off
    drainHigh = 6'h3f;
    repeat (6) cycle();
    check("R10 short relatched", fault, 6'b000100);
    serialCmd = '0;
    cycle();
    check("R10 fault cleared on off", fault, 6'h00);
    check("R10 gate off", gateEn, 6'h00);

    // random healthy-load run, R1 R2 R3 R6 R7
    trackDrain = 1'b1;
    blankLimit = 8'd2;
    cycle();
    for (int n = 0; n < 400; n++) begin
      logic [5:0] e;
      serialCmd   = 6'($urandom);
      parIn       = 6'($urandom);
      selParallel = 1'($urandom);
      pwmLow      = 1'($urandom);
      pwmHigh     = 1'($urandom);
      overVolt    = ($urandom % 10) == 0;
      logicLow    = ($urandom % 10) == 0;
      e = expGate(serialCmd, parIn, selParallel, pwmLow, pwmHigh, overVolt, logicLow);
      cycle();
      check("R1 R2 R3 R6 R7 random gate", gateEn, e);
      check("R4 R5 random no fault", fault, 6'h00);
    end
    finishRun();
  end
endmodule